// File: doc/BRIEF.md
# Lock-Gated Processor Reset Stretcher

This block produces a single processor reset line that also tells the system whether the clock generator is locked. The line is open-drain in character. The block either pulls it low or lets go of it, and an external pull-up sets the released level. The line is held low while the clock source reports no lock and while a reset request is held low. After both conditions clear, the line stays low for a fixed stretch of output-clock cycles and is then released.

The reset request is asynchronous and active low. A glitch far shorter than one clock period is latched at once by an asynchronously set capture flop. That flop also pulls the line low at the moment of capture. The captured request then crosses into the output-clock domain through a chain of synchronizer flops. The capture flop is cleared after the end of that chain has seen it.

The stretch counter runs on the free-running output clock, which keeps toggling during reset. A new request, or a loss of lock, during a stretch clears the count, and the full stretch starts again.

Top module: `lockrst_stretch`

## Requirements
- R1: While `por_n_i` is low, `rst_oe_o` is 1 and `rst_o` is 0. If `por_n_i` rises between two clock edges with `lock_i` high and `req_n_i` high, `rst_oe_o` falls just after the STRETCH-th following rising edge of `clk_i`.
- R2: Whenever `lock_i` is low, `rst_oe_o` is 1 in the same time step, without waiting for a clock edge.
- R3: When `lock_i` returns high between two edges, with no request pending, `rst_oe_o` falls just after the STRETCH-th following rising edge. This holds even if lock was lost part-way through a stretch.
- R4: A low level on `req_n_i` sets `rst_oe_o` to 1 in the same time step, even when the low pulse is much shorter than a clock period.
- R5: A request held low across at least SYNC_STAGES rising edges keeps `rst_oe_o` at 1 for the whole time it is low, however long that is. After `req_n_i` rises, `rst_oe_o` falls just after rising edge number STRETCH+SYNC_STAGES+1.
- R6: A low pulse that starts and ends between two adjacent rising edges is still honoured. `rst_oe_o` falls just after rising edge number STRETCH+2*SYNC_STAGES+1, counted from the end of the pulse.
- R7: A new held request during an active stretch restarts the count from zero. The release timing of R5 applies from the rise of the new request, whatever progress the earlier stretch had made.
- R8: `rst_o` models the line level with its pull-up. It is 0 whenever `rst_oe_o` is 1 and 1 whenever `rst_oe_o` is 0, so the block never actively drives the line high.
- R9: Once released, `rst_oe_o` stays 0 for as long as `lock_i` stays high and `req_n_i` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Output clock that the stretch is counted on; never gated |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| req_n_i | input | 1 | Reset request, active low, asynchronous |
| lock_i | input | 1 | Lock status from the clock generator, 1 = locked |
| rst_o | output | 1 | Line level as seen with the external pull-up (0 = reset asserted) |
| rst_oe_o | output | 1 | Pull-down enable; 1 = line driven low, 0 = released |

## Verification
The bench sweeps short request pulses across every sub-cycle offset. A design that sampled the request on clock edges instead of capturing it would miss these pulses and never assert. The bench also holds requests for lengths from barely synchronized up to well past the stretch. A design that started counting on the falling edge of the request would release while the request was still low. Restarts from a second request and from a loss of lock are placed at several points inside a running stretch. A counter that was not cleared would release early by exactly the progress already made. Every release is checked on its exact edge, so an off-by-one in the terminal count or in the synchronizer latency shows up as a one-cycle miss.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

   typedef enum logic [1:0] {
      LRS_HOLD  = 2'd0,
      LRS_COUNT = 2'd1,
      LRS_DONE  = 2'd2
   } lrs_state_e;

   function automatic int lrs_cnt_w(input int stretch);
      return (stretch < 2) ? 1 : $clog2(stretch);
   endfunction

endpackage

// File: rtl/lrs_req_capture.sv
module lrs_req_capture #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic req_n_i,
   output logic cap_o,
   output logic req_sync_o
);

   logic                   cap_q;
   logic [SYNC_STAGES-1:0] sync_q;

   // asynchronous set by the request; cleared on a clock edge once the
   // synchronizer tail has seen it and the request is no longer low
   always_ff @(posedge clk_i or negedge req_n_i or negedge por_n_i) begin
      if (!por_n_i)       cap_q <= 1'b0;
      else if (!req_n_i)  cap_q <= 1'b1;
      else if (sync_q[SYNC_STAGES-1]) cap_q <= 1'b0;
   end

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_head
            always_ff @(posedge clk_i or negedge por_n_i) begin
               if (!por_n_i) sync_q[0] <= 1'b0;
               else          sync_q[0] <= cap_q;
            end
         end else begin : g_tail
            always_ff @(posedge clk_i or negedge por_n_i) begin
               if (!por_n_i) sync_q[s] <= 1'b0;
               else          sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign cap_o      = cap_q;
   assign req_sync_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/lrs_stretch_ctr.sv
module lrs_stretch_ctr
   import lrs_pkg::*;
#(
   parameter int STRETCH = 1024
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic lock_i,
   input  logic req_sync_i,
   output logic busy_o
);

   localparam int CW = lrs_cnt_w(STRETCH);
   localparam logic [CW-1:0] LAST = CW'(STRETCH - 1);

   lrs_state_e    state_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         state_q <= LRS_HOLD;
         cnt_q   <= '0;
      end else if (!lock_i || req_sync_i) begin
         state_q <= LRS_HOLD;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            LRS_HOLD, LRS_COUNT: begin
               if (cnt_q == LAST) begin
                  state_q <= LRS_DONE;
                  cnt_q   <= '0;
               end else begin
                  state_q <= LRS_COUNT;
                  cnt_q   <= cnt_q + 1'b1;
               end
            end
            default: begin
               state_q <= LRS_DONE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign busy_o = (state_q != LRS_DONE);

endmodule

// File: rtl/lockrst_stretch.sv
module lockrst_stretch #(
   parameter int STRETCH     = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic req_n_i,
   input  logic lock_i,
   output logic rst_o,
   output logic rst_oe_o
);

   generate
      if (STRETCH < 2) begin : g_bad_stretch
         $error("lockrst_stretch: STRETCH must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lockrst_stretch: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic cap;
   logic req_sync;
   logic busy;

   lrs_req_capture #(
      .SYNC_STAGES(SYNC_STAGES)
   ) i_capture (
      .clk_i      (clk_i),
      .por_n_i    (por_n_i),
      .req_n_i    (req_n_i),
      .cap_o      (cap),
      .req_sync_o (req_sync)
   );

   lrs_stretch_ctr #(
      .STRETCH(STRETCH)
   ) i_ctr (
      .clk_i      (clk_i),
      .por_n_i    (por_n_i),
      .lock_i     (lock_i),
      .req_sync_i (req_sync),
      .busy_o     (busy)
   );

   // pull low on: running stretch, no lock, or a request not yet absorbed
   assign rst_oe_o = busy | ~lock_i | cap | req_sync;
   assign rst_o    = ~rst_oe_o;

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
   parameter int STRETCH = 1024
) (
   input logic clk_i,
   input logic por_n_i,
   input logic req_n_i,
   input logic lock_i,
   input logic rst_oe_o,
   input logic busy_i,
   input logic req_sync_i
);

   localparam int RW = $clog2(STRETCH + 1) + 1;

   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)                            run_q <= '0;
      else if (lock_i && !req_sync_i && busy_i) run_q <= run_q + 1'b1;
      else                                     run_q <= '0;
   end

   // R2: loss of lock puts the counter back into the hold state
   a_r2_lockloss_holds: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !lock_i |=> busy_i);

   // R4: a low request always shows on the pull-down enable
   a_r4_req_pulls_low: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !req_n_i |-> rst_oe_o);

   // R7: a synchronized request restarts the stretch
   a_r7_sync_restarts: assert property (@(posedge clk_i) disable iff (!por_n_i)
      req_sync_i |=> busy_i);

   // R5: release happens only after exactly STRETCH clean counting edges
   a_r5_exact_stretch: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $fell(busy_i) |-> (run_q == RW'(STRETCH)));

   // R5: the counting run never exceeds the stretch
   a_r5_no_overrun: assert property (@(posedge clk_i) disable iff (!por_n_i)
      run_q <= RW'(STRETCH));

   // R9: a released line stays released while lock and request are quiet
   a_r9_stays_released: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!busy_i && lock_i && !req_sync_i) |=> !busy_i);

endmodule

bind lockrst_stretch lrs_checker #(
   .STRETCH(STRETCH)
) i_lrs_checker (
   .clk_i      (clk_i),
   .por_n_i    (por_n_i),
   .req_n_i    (req_n_i),
   .lock_i     (lock_i),
   .rst_oe_o   (rst_oe_o),
   .busy_i     (busy),
   .req_sync_i (req_sync)
);

// File: tb/test_lockrst_stretch.sv
`timescale 1ns/1ps
module test_lockrst_stretch;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 16;
   localparam int S          = 2;
   localparam int LONG_LAT   = N + S + 1;
   localparam int SHORT_LAT  = N + 2*S + 1;

   logic clk_i   = 1'b0;
   logic por_n_i = 1'b0;
   logic req_n_i = 1'b1;
   logic lock_i  = 1'b1;
   logic rst_o;
   logic rst_oe_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   lockrst_stretch #(.STRETCH(N), .SYNC_STAGES(S)) i_lockrst_stretch (
      .clk_i    (clk_i),
      .por_n_i  (por_n_i),
      .req_n_i  (req_n_i),
      .lock_i   (lock_i),
      .rst_o    (rst_o),
      .rst_oe_o (rst_oe_o)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // R8: line level is always the inverse of the pull-down enable
   task automatic chk_line(input string tag);
      chk(rst_o, ~rst_oe_o, {tag, " R8 line level"});
   endtask

   // count rising edges after an event; released just after edge k
   task automatic expect_release(input int k, input string tag);
      for (int i = 1; i <= k; i++) begin
         @(posedge clk_i); #1;
         chk(rst_oe_o, (i < k), tag);
      end
      chk_line(tag);
   endtask

   task automatic hold_req(input int h);
      @(posedge clk_i); #3;
      req_n_i = 1'b0;
      #1 chk(rst_oe_o, 1'b1, "R4 immediate on held request");
      for (int i = 0; i < h; i++) begin
         @(posedge clk_i); #1;
         chk(rst_oe_o, 1'b1, "R5 low while request held");
      end
      #2 req_n_i = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      #2 chk(rst_oe_o, 1'b1, "R1 power-on asserted");
      chk_line("R1");
      repeat (3) @(posedge clk_i);
      #1 chk(rst_oe_o, 1'b1, "R1 power-on held");
      #2 por_n_i = 1'b1;
      expect_release(N, "R1 release after power-on");

      // R9 stays released
      for (int i = 0; i < 30; i++) begin
         @(posedge clk_i); #1;
         chk(rst_oe_o, 1'b0, "R9 stays released");
      end

      // R2 / R3 lock loss from idle
      @(posedge clk_i); #3;
      lock_i = 1'b0;
      #1 chk(rst_oe_o, 1'b1, "R2 immediate on lock loss");
      chk_line("R2");
      repeat (3) begin
         @(posedge clk_i); #1;
         chk(rst_oe_o, 1'b1, "R2 low while unlocked");
      end
      #2 lock_i = 1'b1;
      expect_release(N, "R3 release after relock");

      // R5 held requests of many lengths, including beyond the stretch
      for (int h = S; h <= 6; h++) begin
         hold_req(h);
         expect_release(LONG_LAT, "R5 long request release");
      end
      hold_req(3*N);
      expect_release(LONG_LAT, "R5 very long request release");

      // R6 sub-cycle pulses at every offset that fits in one period
      for (int off = 1; off <= 6; off++) begin
         @(posedge clk_i); #(off);
         req_n_i = 1'b0;
         #1 chk(rst_oe_o, 1'b1, "R4 immediate on short pulse");
         #1 req_n_i = 1'b1;
         expect_release(SHORT_LAT, "R6 short pulse release");
      end

      // R7 second request during a running stretch
      for (int j = 4; j <= N; j += 6) begin
         hold_req(S);
         for (int i = 0; i < j; i++) begin
            @(posedge clk_i); #1;
            chk(rst_oe_o, 1'b1, "R7 first stretch running");
         end
         #2;
         hold_req(S);
         expect_release(LONG_LAT, "R7 restart on new request");
      end

      // R3 lock loss part-way through a stretch
      for (int j = 4; j <= 12; j += 8) begin
         hold_req(S);
         for (int i = 0; i < j; i++) begin
            @(posedge clk_i); #1;
            chk(rst_oe_o, 1'b1, "R3 stretch running");
         end
         #2 lock_i = 1'b0;
         #1 chk(rst_oe_o, 1'b1, "R2 lock loss mid stretch");
         @(posedge clk_i); #3;
         lock_i = 1'b1;
         expect_release(N, "R3 full stretch after relock");
      end

      for (int i = 0; i < 10; i++) begin
         @(posedge clk_i); #1;
         chk(rst_oe_o, 1'b0, "R9 quiet at end");
         chk_line("R9");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule